// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block moves outgoing frames from memory to a byte stream. Software places a chain of descriptors in memory. Each descriptor is three little-endian 32-bit words: where the frame buffer starts, a size word, and where the next descriptor sits. Software loads the chain's start address into the base register and writes the start bit of the control register. The walker then reads descriptors one after another over a single 32-bit memory master port, which allows one read in flight at a time. For every descriptor that holds a frame, it streams the buffer out byte by byte, marks the final byte, and writes the size word back with its empty flag set so the slot returns to software. A one-cycle completion pulse marks each frame.

Each frame goes to the transmit stream. When the loopback input is high, the frame goes to the local receive stream instead. The walk ends at the first descriptor whose empty flag is set. At that point the walker raises the underrun flag and the hardware clears the DMA enable. Both byte streams are valid/ready. Once valid rises, it stays high, and the data and last marker stay stable, until the consumer takes the byte with ready. A consumer that holds ready low only stalls the walker and never loses a byte. The memory request follows the same rule: valid, address, write flag and write data hold until ready is seen.

Top module: `txdesc_walker`

## Requirements
- R1: After reset `dma_en`, `underrun`, `pkt_done`, `mem_req_valid`, `tx_valid` and `lb_valid` are all low.
- R2: A write with `reg_wr_sel`=0 and `reg_wr_data` bit 0 set starts a walk only while `cfg_tx_en` is high and no walk is running. Otherwise the write starts nothing: `dma_en` stays low and no memory request is issued.
- R3: A write with `reg_wr_sel`=1 loads the base register with bits 1:0 forced to zero. The walk's first memory read is at that aligned address.
- R4: For the descriptor at address D the walker reads D (buffer address), D+4 (size word: bit 31 = empty, bits 10:0 = length in bytes) and D+8 (next address).
- R5: A frame's bytes leave in ascending address order from any starting byte offset. Within each little-endian word, bits 7:0 come first. Exactly the length's worth of bytes is sent, and `last` is high on the final byte only.
- R6: After a frame's final byte, the walker writes the size word with bit 31 set back to D+4. It then pulses `pkt_done` for one cycle, once per frame.
- R7: The next descriptor is read from the address held in the third word of the current one.
- R8: On reading a descriptor whose empty bit is set, the walker sends no bytes and writes nothing back. It sets `underrun` and clears `dma_en`.
- R9: With `cfg_loopback` high when a descriptor's third word arrives, that frame goes to the `lb_*` stream only. Otherwise it goes to the `tx_*` stream only.
- R10: While a stream's valid is high and its ready is low, valid stays high and data and last stay unchanged on the next cycle.
- R11: A memory request that is not accepted stays valid with the same address and direction. A new read is issued only after the previous read's response.
- R12: A descriptor with length 0 and the empty bit clear sends no bytes but is still written back and counted with `pkt_done`.
- R13: Starting a new walk clears `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_en | input | 1 | Transmit path enable from the configuration |
| cfg_loopback | input | 1 | Route frames to the local receive stream |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 = control register, 1 = base register |
| reg_wr_data | input | 32 | Register write data |
| dma_en | output | 1 | Walk in progress (enable bit) |
| underrun | output | 1 | Walk ended on an empty descriptor |
| pkt_done | output | 1 | One-cycle pulse per completed frame |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address, word aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit consumer ready |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of frame |
| lb_valid | output | 1 | Loopback byte valid |
| lb_ready | input | 1 | Loopback consumer ready |
| lb_data | output | 8 | Loopback byte |
| lb_last | output | 1 | Final byte of frame |

## Verification
The hardest condition to reach is a frame that starts mid-word, is cut across several buffer word fetches, and has its byte stream stalled at the same time. The memory acceptance and the response pacing must interleave with consumer back-pressure at every lane boundary. The stimulus table combines unaligned buffer offsets, loopback and four consumer ready patterns, one of which is pseudo-random. The memory model refuses one request in three. A directed chain then mixes a zero-length descriptor between two real frames, so that the chain-following and write-back sequences run without any byte traffic.

// File: rtl/txw_pkg.sv
package txw_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned EMPTY_BIT = 31;
  localparam logic        SEL_CTL   = 1'b0;
  localparam logic        SEL_BASE  = 1'b1;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_DREQ,
    WK_DRSP,
    WK_BREQ,
    WK_BRSP,
    WK_EMIT,
    WK_WB
  } walk_st_t;
endpackage

// File: rtl/txw_regs.sv
module txw_regs
  import txw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              tx_cfg_en,
  input  logic              stop_empty,
  output logic              start,
  output logic              en_q,
  output logic              underrun_q,
  output logic [ADDR_W-1:0] base_q
);
  logic unused_lsb;
  assign unused_lsb = ^wr_data[1:0];

  // a walk begins only from idle and only with the transmit path enabled
  assign start = wr_en && (wr_sel == SEL_CTL) && wr_data[0] && tx_cfg_en && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      underrun_q <= 1'b0;
      base_q     <= '0;
    end else begin
      if (start) begin
        en_q       <= 1'b1;
        underrun_q <= 1'b0;
      end else if (stop_empty) begin
        en_q       <= 1'b0;
        underrun_q <= 1'b1;
      end
      if (wr_en && (wr_sel == SEL_BASE))
        base_q <= {wr_data[ADDR_W-1:2], 2'b00};
    end
  end

  // R8
  underrun_ends_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun_q) |-> !en_q);
  // R13
  start_clears_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!underrun_q && en_q));
endmodule

// File: rtl/txw_walker.sv
module txw_walker
  import txw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic              loopback,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_rdata,
  output logic              emit_valid,
  output logic [WORD_W-1:0] emit_word,
  output logic [1:0]        emit_lane,
  output logic              emit_last,
  output logic              emit_route,
  input  logic              emit_fire,
  output logic              stop_empty,
  output logic              pkt_done
);
  localparam logic [ADDR_W-1:0] SIZE_OFS = ADDR_W'(4);

  walk_st_t          st;
  logic [ADDR_W-1:0] desc_q;
  logic [ADDR_W-1:0] buf_ptr;
  logic [ADDR_W-1:0] next_q;
  logic [WORD_W-1:0] size_q;
  logic [WORD_W-1:0] word_q;
  logic [LEN_W-1:0]  remain;
  logic [1:0]        dw_idx;
  logic              route_q;
  logic [LEN_W-1:0]  new_len;

  assign new_len = size_q[LEN_W-1:0];

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    unique case (st)
      WK_DREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = desc_q + ADDR_W'({dw_idx, 2'b00});
      end
      WK_BREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = {buf_ptr[ADDR_W-1:2], 2'b00};
      end
      WK_WB: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = desc_q + SIZE_OFS;
        mem_req_wdata = size_q | (WORD_W'(1) << EMPTY_BIT);
      end
      default: ;
    endcase
  end

  assign emit_valid = (st == WK_EMIT);
  assign emit_word  = word_q;
  assign emit_lane  = buf_ptr[1:0];
  assign emit_last  = (remain == LEN_W'(1));
  assign emit_route = route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= WK_IDLE;
      desc_q     <= '0;
      buf_ptr    <= '0;
      next_q     <= '0;
      size_q     <= '0;
      word_q     <= '0;
      remain     <= '0;
      dw_idx     <= '0;
      route_q    <= 1'b0;
      stop_empty <= 1'b0;
      pkt_done   <= 1'b0;
    end else begin
      stop_empty <= 1'b0;
      pkt_done   <= 1'b0;
      unique case (st)
        WK_IDLE: if (start) begin
          desc_q <= base;
          dw_idx <= '0;
          st     <= WK_DREQ;
        end
        WK_DREQ: if (mem_req_ready) st <= WK_DRSP;
        WK_DRSP: if (mem_rsp_valid) begin
          unique case (dw_idx)
            2'd0:    buf_ptr <= mem_rsp_rdata[ADDR_W-1:0];
            2'd1:    size_q  <= mem_rsp_rdata;
            default: next_q  <= mem_rsp_rdata[ADDR_W-1:0];
          endcase
          if (dw_idx == 2'd2) begin
            dw_idx <= '0;
            if (size_q[EMPTY_BIT]) begin
              stop_empty <= 1'b1;
              st         <= WK_IDLE;
            end else begin
              route_q <= loopback;
              remain  <= new_len;
              st      <= (new_len == '0) ? WK_WB : WK_BREQ;
            end
          end else begin
            dw_idx <= dw_idx + 2'd1;
            st     <= WK_DREQ;
          end
        end
        WK_BREQ: if (mem_req_ready) st <= WK_BRSP;
        WK_BRSP: if (mem_rsp_valid) begin
          word_q <= mem_rsp_rdata;
          st     <= WK_EMIT;
        end
        WK_EMIT: if (emit_fire) begin
          buf_ptr <= buf_ptr + ADDR_W'(1);
          remain  <= remain - LEN_W'(1);
          if (remain == LEN_W'(1))     st <= WK_WB;
          else if (buf_ptr[1:0] == 2'd3) st <= WK_BREQ;
        end
        WK_WB: if (mem_req_ready) begin
          pkt_done <= 1'b1;
          desc_q   <= next_q;
          st       <= WK_DREQ;
        end
        default: st <= WK_IDLE;
      endcase
    end
  end

  // R11
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));
  // R6
  pkt_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);
  // R11
  rsp_only_when_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && !mem_req_we) |=> !mem_req_valid);
endmodule

// File: rtl/txw_lane_out.sv
module txw_lane_out
  import txw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit_valid,
  input  logic [WORD_W-1:0] emit_word,
  input  logic [1:0]        emit_lane,
  input  logic              emit_last,
  input  logic              emit_route,
  output logic              emit_fire,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              lb_valid,
  input  logic              lb_ready,
  output logic [7:0]        lb_data,
  output logic              lb_last
);
  localparam int unsigned NCH = 2;

  logic [7:0]     cur_byte;
  logic [NCH-1:0] ch_valid;
  logic [NCH-1:0] ch_ready;
  logic [NCH-1:0] ch_fire;

  assign cur_byte = emit_word[{emit_lane, 3'b000} +: 8];
  assign ch_ready = {lb_ready, tx_ready};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_valid[g] = emit_valid && (emit_route == g[0]);
    assign ch_fire[g]  = ch_valid[g] && ch_ready[g];
  end

  assign emit_fire = |ch_fire;
  assign tx_valid  = ch_valid[0];
  assign lb_valid  = ch_valid[1];
  assign tx_data   = cur_byte;
  assign lb_data   = cur_byte;
  assign tx_last   = emit_last;
  assign lb_last   = emit_last;

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  // R10
  lb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_valid && !lb_ready) |=> (lb_valid && $stable(lb_data) && $stable(lb_last)));
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
  import txw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tx_en,
  input  logic              cfg_loopback,
  input  logic              reg_wr_en,
  input  logic              reg_wr_sel,
  input  logic [31:0]       reg_wr_data,
  output logic              dma_en,
  output logic              underrun,
  output logic              pkt_done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              lb_valid,
  input  logic              lb_ready,
  output logic [7:0]        lb_data,
  output logic              lb_last
);
  logic              start;
  logic              stop_empty;
  logic [ADDR_W-1:0] base_q;
  logic              emit_valid;
  logic [WORD_W-1:0] emit_word;
  logic [1:0]        emit_lane;
  logic              emit_last;
  logic              emit_route;
  logic              emit_fire;

  txw_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .wr_sel     (reg_wr_sel),
    .wr_data    (reg_wr_data),
    .tx_cfg_en  (cfg_tx_en),
    .stop_empty (stop_empty),
    .start      (start),
    .en_q       (dma_en),
    .underrun_q (underrun),
    .base_q     (base_q)
  );

  txw_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .base          (base_q),
    .loopback      (cfg_loopback),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .emit_valid    (emit_valid),
    .emit_word     (emit_word),
    .emit_lane     (emit_lane),
    .emit_last     (emit_last),
    .emit_route    (emit_route),
    .emit_fire     (emit_fire),
    .stop_empty    (stop_empty),
    .pkt_done      (pkt_done)
  );

  txw_lane_out u_lane (
    .clk        (clk),
    .rst_n      (rst_n),
    .emit_valid (emit_valid),
    .emit_word  (emit_word),
    .emit_lane  (emit_lane),
    .emit_last  (emit_last),
    .emit_route (emit_route),
    .emit_fire  (emit_fire),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .lb_valid   (lb_valid),
    .lb_ready   (lb_ready),
    .lb_data    (lb_data),
    .lb_last    (lb_last)
  );

  // R2
  idle_no_traffic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !$past(dma_en)) |-> !mem_req_valid);
  // R8
  no_bytes_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> (!tx_valid && !lb_valid));
endmodule

// File: tb/txdesc_walker_bench.sv
module txdesc_walker_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_tx_en = 1'b0, cfg_loopback = 1'b0;
  logic        reg_wr_en = 1'b0, reg_wr_sel = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic        dma_en, underrun, pkt_done;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        tx_valid, tx_last, lb_valid, lb_last;
  logic        tx_ready, lb_ready;
  logic [7:0]  tx_data, lb_data;

  txdesc_walker u_txdesc_walker (.*);

  // memory model and stream sinks
  logic [31:0] mem [0:255];
  logic        hw_en = 1'b0;
  logic [31:0] hw_addr = '0, hw_data = '0;
  logic [1:0]  sink_mode = 2'd0;
  logic        clr_cap = 1'b0, arm_first = 1'b0;
  logic [7:0]  cap_data [0:63];
  logic        cap_route [0:63];
  logic        cap_lastf [0:63];
  int          cap_n = 0, done_cnt = 0, req_cnt = 0, wb_cnt = 0;
  int          s_viol = 0, m_viol = 0, cyc = 0;
  logic [31:0] first_addr = '0;
  logic        first_seen = 1'b0;
  logic [7:0]  lfsr = 8'h5B;
  logic        p_tv = 0, p_tr = 0, p_lv = 0, p_lr = 0, p_mv = 0, p_mr = 0, p_mw = 0;
  logic [7:0]  p_td = 0, p_ld = 0;
  logic [31:0] p_ma = 0;

  function automatic logic sink_rdy(input logic [1:0] m, input int c, input logic r);
    case (m)
      2'd0: return 1'b1;
      2'd1: return c[0];
      2'd2: return (c % 3) == 0;
      default: return r;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= (cyc % 3) != 2;
    tx_ready <= sink_rdy(sink_mode, cyc, lfsr[0]);
    lb_ready <= sink_rdy(sink_mode, cyc + 1, lfsr[1]);
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      req_cnt <= req_cnt + 1;
      if (!first_seen && !arm_first) begin first_addr <= mem_req_addr; first_seen <= 1'b1; end
      if (mem_req_we) begin mem[mem_req_addr[9:2]] <= mem_req_wdata; wb_cnt <= wb_cnt + 1; end
      else begin mem_rsp_valid <= 1'b1; mem_rsp_rdata <= mem[mem_req_addr[9:2]]; end
    end
    if (arm_first) first_seen <= 1'b0;
    if (hw_en) mem[hw_addr[9:2]] <= hw_data;
    // back-pressure and request-hold monitors
    if (p_tv && !p_tr && (!tx_valid || tx_data != p_td)) s_viol <= s_viol + 1;
    if (p_lv && !p_lr && (!lb_valid || lb_data != p_ld)) s_viol <= s_viol + 1;
    if (p_mv && !p_mr && (!mem_req_valid || mem_req_addr != p_ma || mem_req_we != p_mw)) m_viol <= m_viol + 1;
    p_tv <= tx_valid; p_tr <= tx_ready; p_td <= tx_data;
    p_lv <= lb_valid; p_lr <= lb_ready; p_ld <= lb_data;
    p_mv <= mem_req_valid; p_mr <= mem_req_ready; p_ma <= mem_req_addr; p_mw <= mem_req_we;
    if (clr_cap) begin
      cap_n <= 0; done_cnt <= 0;
    end else begin
      if (pkt_done) done_cnt <= done_cnt + 1;
      if (tx_valid && tx_ready && cap_n < 64) begin
        cap_data[cap_n] <= tx_data; cap_route[cap_n] <= 1'b0; cap_lastf[cap_n] <= tx_last; cap_n <= cap_n + 1;
      end else if (lb_valid && lb_ready && cap_n < 64) begin
        cap_data[cap_n] <= lb_data; cap_route[cap_n] <= 1'b1; cap_lastf[cap_n] <= lb_last; cap_n <= cap_n + 1;
      end
    end
  end

  int n_checks = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bp(input logic [31:0] a);
    return 8'(a[9:0] * 10'd13 + 10'h21);
  endfunction

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); hw_en = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk); hw_en = 1'b0;
  endtask

  task automatic regw(input logic sel, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic clear_cap();
    @(negedge clk); clr_cap = 1'b1; arm_first = 1'b1;
    @(negedge clk); clr_cap = 1'b0; arm_first = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 5000 && dma_en; n++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // {stall[15:14], loopback[13], offset[12:11], len[10:0]}
  localparam logic [15:0] VEC [6] = '{
    {2'd0, 1'b0, 2'd0, 11'd1},
    {2'd1, 1'b0, 2'd0, 11'd5},
    {2'd0, 1'b1, 2'd3, 11'd7},
    {2'd2, 1'b0, 2'd1, 11'd4},
    {2'd1, 1'b1, 2'd2, 11'd9},
    {2'd3, 1'b0, 2'd0, 11'd12}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int r0, w0, bad, lasts;
    logic [31:0] b;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dma_en", dma_en, 0);
    chk("R1 underrun", underrun, 0);
    chk("R1 pkt_done", pkt_done, 0);
    chk("R1 req_valid", mem_req_valid, 0);
    chk("R1 stream valid", {tx_valid, lb_valid}, 0);
    rst_n = 1'b1;
    for (int w = 128; w < 192; w++)
      poke(w * 4, {bp(w*4+3), bp(w*4+2), bp(w*4+1), bp(w*4)});

    // R2 start ignored with transmit path disabled
    poke(32'h104, 32'h8000_0000);
    r0 = req_cnt;
    regw(1'b1, 32'h103);
    regw(1'b0, 32'h1);
    repeat (10) @(negedge clk);
    chk("R2 dma_en stays low", dma_en, 0);
    chk("R2 no requests", req_cnt - r0, 0);

    // R3 alignment, R4 three reads, R8 empty stop
    cfg_tx_en = 1'b1;
    clear_cap();
    r0 = req_cnt; w0 = wb_cnt;
    regw(1'b0, 32'h1);
    wait_idle();
    chk("R3 first read aligned", first_addr, 32'h100);
    chk("R4 three descriptor reads", req_cnt - r0, 3);
    chk("R8 underrun set", underrun, 1);
    chk("R8 dma_en cleared", dma_en, 0);
    chk("R8 no bytes", cap_n, 0);
    chk("R8 no writeback", wb_cnt - w0, 0);

    // R13 restart clears underrun
    regw(1'b0, 32'h1);
    chk("R13 underrun cleared on start", underrun, 0);
    wait_idle();
    chk("R13 underrun again", underrun, 1);

    // table of frames: R5 R9 R10 R11
    for (int i = 0; i < 6; i++) begin
      logic [10:0] len;
      logic        lb;
      len = VEC[i][10:0]; lb = VEC[i][13];
      b = 32'h200 + i * 16 + VEC[i][12:11];
      poke(32'h40, b); poke(32'h44, {21'd0, len}); poke(32'h48, 32'h50);
      poke(32'h54, 32'h8000_0000);
      sink_mode = VEC[i][15:14]; cfg_loopback = lb;
      clear_cap();
      regw(1'b1, 32'h40);
      regw(1'b0, 32'h1);
      wait_idle();
      bad = 0; lasts = 0;
      for (int k = 0; k < 64 && k < cap_n; k++) begin
        if (cap_data[k] !== bp(b + k)) bad++;
        if (cap_route[k] !== lb) bad++;
        if (cap_lastf[k]) lasts++;
      end
      chk($sformatf("R5 vec%0d byte count", i), cap_n, len);
      chk($sformatf("R5 R9 vec%0d byte/route mismatches", i), bad, 0);
      chk($sformatf("R5 vec%0d single last", i), lasts, 1);
      chk($sformatf("R5 vec%0d last on final", i), cap_lastf[len-1], 1);
      chk($sformatf("R6 vec%0d writeback", i), mem[17], {1'b1, 20'd0, len});
      chk($sformatf("R6 vec%0d pkt_done count", i), done_cnt, 1);
      chk($sformatf("R8 vec%0d underrun at end", i), underrun, 1);
    end
    chk("R10 stream hold violations", s_viol, 0);
    chk("R11 request hold violations", m_viol, 0);

    // R7 chain, R12 zero length frame
    cfg_loopback = 1'b0; sink_mode = 2'd1;
    poke(32'h00, 32'h280); poke(32'h04, 32'd3); poke(32'h08, 32'h10);
    poke(32'h10, 32'h290); poke(32'h14, 32'd0); poke(32'h18, 32'h20);
    poke(32'h20, 32'h2A1); poke(32'h24, 32'd6); poke(32'h28, 32'h30);
    poke(32'h34, 32'h8000_0000);
    clear_cap();
    w0 = wb_cnt;
    regw(1'b1, 32'h0);
    regw(1'b0, 32'h1);
    wait_idle();
    bad = 0; lasts = 0;
    for (int k = 0; k < 9 && k < cap_n; k++) begin
      if (cap_data[k] !== ((k < 3) ? bp(32'h280 + k) : bp(32'h2A1 + k - 3))) bad++;
      if (cap_lastf[k]) lasts++;
    end
    chk("R7 chained byte count", cap_n, 9);
    chk("R7 chained byte order", bad, 0);
    chk("R12 last markers", lasts, 2);
    chk("R7 R12 pkt_done count", done_cnt, 3);
    chk("R12 writebacks", wb_cnt - w0, 3);
    chk("R12 zero-length writeback", mem[5], 32'h8000_0000);
    chk("R6 chained writeback", mem[9], 32'h8000_0006);
    chk("R10 R11 hold after chain", s_viol + m_viol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule